// File: doc/BRIEF.md
# Reset, Idle and Power-Down Controller

This block decides the operating mode of a small microcontroller core and turns that mode into clock enables. It samples the raw oscillator clock. A divide-by-two phase flop in the block sets the instants at which the internal reset may be released. Software asks for a low-power mode with a one-cycle request: idle stops only the CPU clock, while power-down also stops the peripheral clock and the oscillator. A hardware reset pin, qualified over two machine cycles of the running oscillator, produces the synchronous reset for the special-function registers.

Idle ends on the OR of enabled pending interrupts or on the reset pin. When the reset pin ends idle, the CPU resumes at once and runs until the qualified reset takes over. During that window the block raises a signal that blocks writes to internal RAM; port writes are left alone.

Power-down ends only through the reset pin. Leaving power-down restarts the oscillator and waits a fixed start-up count with the CPU and peripherals held. The reset stays asserted for as long as the pin is high. A machine cycle is two oscillator clocks per state times `STATES_PER_MC` states. With the defaults (6 states, 2 machine cycles, 16 start-up clocks), qualification takes 24 oscillator clocks.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While `por_n` is sampled low, `sfr_rst`, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1 and `ram_wr_inhibit` is 0. After `por_n` goes high, `sfr_rst` is still 1 after the first edge and 0 after the second edge.
- R2: While the oscillator runs (run or idle mode), `sfr_rst` rises at the 24th consecutive rising edge that samples `rst_pin` high (2 machine cycles of 12 clocks each). A high pulse of 23 edges or fewer leaves `sfr_rst` at 0.
- R3: Once asserted, `sfr_rst` stays 1 while `rst_pin` is high. After `rst_pin` falls, `sfr_rst` returns to 0 within two edges, only at an edge where the divided phase flop is 1.
- R4: An `idle_req` sampled in run mode with `sfr_rst` low and `pd_req` low gives `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1 after that edge.
- R5: In idle, the edge that samples `irq_pend` high sets `cpu_clk_en` to 1.
- R6: A `pd_req` sampled in run mode with `sfr_rst` low clears all three enables after that edge, even when `idle_req` is high in the same cycle.
- R7: In power-down, `irq_pend` and `idle_req` are ignored and `osc_en` stays 0; only `rst_pin` high ends it.
- R8: The edge that samples `rst_pin` high in power-down sets `osc_en`=1 and `sfr_rst`=1 while `cpu_clk_en` stays 0. `cpu_clk_en` returns to 1 exactly 16 edges later, and `sfr_rst` holds while the pin stays high.
- R9: The edge that samples `rst_pin` high in idle sets `cpu_clk_en`=1 and `ram_wr_inhibit`=1 with `sfr_rst`=0. The inhibit stays high for 23 edges and falls at the edge where `sfr_rst` rises; both are never 1 together.
- R10: While `sfr_rst` is 1, `idle_req` and `pd_req` are ignored and the CPU clock keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Synchronous active-low power-on reset of the controller itself |
| rst_pin | input | 1 | Hardware reset pin, active high |
| idle_req | input | 1 | One-cycle software request for idle |
| pd_req | input | 1 | One-cycle software request for power-down |
| irq_pend | input | 1 | OR of enabled pending interrupts |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable (timers, serial, interrupt logic, RAM) |
| osc_en | output | 1 | Oscillator enable |
| sfr_rst | output | 1 | Internal synchronous reset for special-function registers |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes while a reset pulse ends idle |

## Verification
An idle request and a power-down request can land in the same clock, and the bench raises both together in one step of its request sweep. Power-down must win: all three enables must be low on the next sample, and only the reset pin may bring them back. A second collision is an idle exit caused by the reset pin, where CPU resumption and the still-unqualified reset overlap. The bench counts the inhibit window edge by edge and expects its end to coincide exactly with the rise of the internal reset.

// File: rtl/pmc_pkg.sv
// Package: shared mode encoding for the power-mode controller.
// Assumes: two-bit state is enough for the four operating modes.
package pmc_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2,
        MODE_START = 2'd3
    } pmode_t;
endpackage

// File: rtl/pmc_phase_div.sv
// Module: divide-by-two phase flop that times reset release.
// Assumes: run is high only while the oscillator is stable; the phase freezes otherwise.
module pmc_phase_div (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic phase
);
    // Toggle the phase on every running oscillator edge.
    always_ff @(posedge clk) begin
        if (!por_n)   phase <= 1'b0;
        else if (run) phase <= ~phase;
    end
endmodule

// File: rtl/pmc_rst_qual.sv
// Module: qualifies the reset pin over a number of oscillator clocks.
// Assumes: counting only while the oscillator runs; any low sample restarts the count.
module pmc_rst_qual #(
    parameter int QUAL_CLKS = 24
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic osc_run,
    output logic hold
);
    localparam int CW = (QUAL_CLKS > 1) ? $clog2(QUAL_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

    logic [CW-1:0] cnt;

    // Count consecutive qualified high samples, saturating one below the limit.
    always_ff @(posedge clk) begin
        if (!por_n)                   cnt <= '0;
        else if (!(rst_pin && osc_run)) cnt <= '0;
        else if (cnt != LAST)         cnt <= cnt + 1'b1;
    end

    // The limit-th consecutive high sample requests reset.
    assign hold = rst_pin && osc_run && (cnt == LAST);
endmodule

// File: rtl/pmc_start_timer.sv
// Module: oscillator start-up delay after leaving power-down.
// Assumes: START_CLKS >= 2; active stays high for the whole start-up state.
module pmc_start_timer #(
    parameter int START_CLKS = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic active,
    output logic done
);
    localparam int SW = (START_CLKS > 1) ? $clog2(START_CLKS) : 1;
    localparam logic [SW-1:0] LAST = SW'(START_CLKS - 1);

    logic [SW-1:0] cnt;

    // Count start-up clocks; clear whenever not starting.
    always_ff @(posedge clk) begin
        if (!por_n || !active) cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    // Final start-up clock reached.
    assign done = active && (cnt == LAST);
endmodule

// File: rtl/pmc_mode_fsm.sv
// Module: operating-mode state machine (run, idle, power-down, start-up).
// Assumes: requests are single-cycle; power-down wins over idle; in_reset blocks requests.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   rst_pin,
    input  logic   idle_req,
    input  logic   pd_req,
    input  logic   irq_pend,
    input  logic   in_reset,
    input  logic   start_done,
    output pmode_t mode
);
    pmode_t mode_nx;

    // Next-mode selection with wake sources per mode.
    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_RUN: begin
                if (!in_reset) begin
                    if (pd_req)        mode_nx = MODE_PDOWN;
                    else if (idle_req) mode_nx = MODE_IDLE;
                end
            end
            MODE_IDLE:  if (rst_pin || irq_pend) mode_nx = MODE_RUN;
            MODE_PDOWN: if (rst_pin)             mode_nx = MODE_START;
            MODE_START: if (start_done)          mode_nx = MODE_RUN;
            default:                             mode_nx = MODE_RUN;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!por_n) mode <= MODE_RUN;
        else        mode <= mode_nx;
    end
endmodule

// File: rtl/pwrmode_ctrl.sv
// Module: top of the reset, idle and power-down controller.
// Assumes: clk is the raw oscillator; one machine cycle is 2*STATES_PER_MC clocks;
// por_n is a synchronous active-low reset of this controller only.
module pwrmode_ctrl
    import pmc_pkg::*;
#(
    parameter int STATES_PER_MC = 6,
    parameter int RST_MC        = 2,
    parameter int START_CLKS    = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic idle_req,
    input  logic pd_req,
    input  logic irq_pend,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic sfr_rst,
    output logic ram_wr_inhibit
);
    localparam int MC_CLKS   = 2 * STATES_PER_MC;
    localparam int QUAL_CLKS = MC_CLKS * RST_MC;

    pmode_t mode;
    logic   osc_run;
    logic   phase;
    logic   qual_hold;
    logic   start_done;
    logic   rst_set;
    logic   sfr_rst_nx;
    logic   inhibit_nx;

    assign osc_run = (mode == MODE_RUN) || (mode == MODE_IDLE);

    pmc_phase_div u_div (
        .clk   (clk),
        .por_n (por_n),
        .run   (osc_run),
        .phase (phase)
    );

    pmc_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
        .clk     (clk),
        .por_n   (por_n),
        .rst_pin (rst_pin),
        .osc_run (osc_run),
        .hold    (qual_hold)
    );

    pmc_start_timer #(.START_CLKS(START_CLKS)) u_start (
        .clk    (clk),
        .por_n  (por_n),
        .active (mode == MODE_START),
        .done   (start_done)
    );

    pmc_mode_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .rst_pin    (rst_pin),
        .idle_req   (idle_req),
        .pd_req     (pd_req),
        .irq_pend   (irq_pend),
        .in_reset   (sfr_rst),
        .start_done (start_done),
        .mode       (mode)
    );

    // Reset is set by qualification, held by the pin, and forced across start-up.
    assign rst_set = qual_hold
                   || (sfr_rst && rst_pin)
                   || ((mode == MODE_PDOWN) && rst_pin)
                   || (mode == MODE_START);

    // Next internal reset: release only on a phase boundary.
    always_comb begin
        if (rst_set)    sfr_rst_nx = 1'b1;
        else if (phase) sfr_rst_nx = 1'b0;
        else            sfr_rst_nx = sfr_rst;
    end

    // Inhibit opens when the pin wakes idle and closes when reset takes over or the pin drops.
    assign inhibit_nx = rst_pin && !sfr_rst_nx && ((mode == MODE_IDLE) || ram_wr_inhibit);

    // Internal reset and RAM inhibit registers.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            sfr_rst        <= 1'b1;
            ram_wr_inhibit <= 1'b0;
        end else begin
            sfr_rst        <= sfr_rst_nx;
            ram_wr_inhibit <= inhibit_nx;
        end
    end

    // Clock enables decoded from the mode.
    assign cpu_clk_en = (mode == MODE_RUN);
    assign per_clk_en = osc_run;
    assign osc_en     = (mode != MODE_PDOWN);
endmodule

// File: rtl/pwrmode_ctrl_chk.sv
// Module: property checker for pwrmode_ctrl, attached by bind.
// Assumes: phase is the controller's divided phase flop.
module pwrmode_ctrl_chk (
    input logic clk,
    input logic por_n,
    input logic rst_pin,
    input logic idle_req,
    input logic pd_req,
    input logic irq_pend,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_en,
    input logic sfr_rst,
    input logic ram_wr_inhibit,
    input logic phase
);
    // R6
    pd_priority_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_clk_en && !sfr_rst && pd_req) |=> (!osc_en && !per_clk_en && !cpu_clk_en));

    // R4
    idle_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_clk_en && !sfr_rst && idle_req && !pd_req) |=> (!cpu_clk_en && per_clk_en && osc_en));

    // R5
    idle_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!cpu_clk_en && per_clk_en && irq_pend) |=> cpu_clk_en);

    // R7
    pd_stay_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!osc_en && !rst_pin) |=> !osc_en);

    // R8
    pd_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(osc_en) |-> (sfr_rst && !cpu_clk_en));

    // R3
    release_phase_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sfr_rst) |-> ($past(phase) && !$past(rst_pin)));

    // R9
    inhibit_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        ram_wr_inhibit |-> (!sfr_rst && cpu_clk_en));

    // R10
    reset_block_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sfr_rst && cpu_clk_en) |=> cpu_clk_en);
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk chk_i (
    .clk            (clk),
    .por_n          (por_n),
    .rst_pin        (rst_pin),
    .idle_req       (idle_req),
    .pd_req         (pd_req),
    .irq_pend       (irq_pend),
    .cpu_clk_en     (cpu_clk_en),
    .per_clk_en     (per_clk_en),
    .osc_en         (osc_en),
    .sfr_rst        (sfr_rst),
    .ram_wr_inhibit (ram_wr_inhibit),
    .phase          (phase)
);

// File: tb/pwrmode_ctrl_tb_top.sv
// Bench: sweeps reset pulse lengths and request combinations; expected values from the requirements.
module pwrmode_ctrl_tb_top;
    localparam int STATES_PER_MC = 6;
    localparam int RST_MC        = 2;
    localparam int START_CLKS    = 16;
    localparam int QUAL          = 2 * STATES_PER_MC * RST_MC;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0, irq_pend = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_en, sfr_rst, ram_wr_inhibit;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwrmode_ctrl #(
        .STATES_PER_MC(STATES_PER_MC), .RST_MC(RST_MC), .START_CLKS(START_CLKS)
    ) dut_i (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .idle_req(idle_req),
        .pd_req(pd_req), .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .sfr_rst(sfr_rst),
        .ram_wr_inhibit(ram_wr_inhibit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic int ens();
        return {29'd0, cpu_clk_en, per_clk_en, osc_en};
    endfunction

    initial begin
        int first;
        int exp_first;
        int n;
        int win;
        ticks(4);
        // R1 reset state
        check(sfr_rst == 1'b1, "R1 sfr_rst during por", sfr_rst, 1);
        check(ens() == 7, "R1 enables during por", ens(), 7);
        check(ram_wr_inhibit == 1'b0, "R1 inhibit during por", ram_wr_inhibit, 0);
        por_n = 1'b1;
        tick();
        check(sfr_rst == 1'b1, "R1 held after first edge", sfr_rst, 1);
        tick();
        check(sfr_rst == 1'b0, "R1 released after second edge", sfr_rst, 0);
        ticks(3);

        // R2 / R3 sweep of pulse lengths in run mode
        for (int len = 1; len <= QUAL + 6; len++) begin
            first = 0;
            rst_pin = 1'b1;
            for (int k = 1; k <= len; k++) begin
                tick();
                if (sfr_rst && first == 0) first = k;
            end
            exp_first = (len >= QUAL) ? QUAL : 0;
            check(first == exp_first, "R2 reset rise edge", first, exp_first);
            if (len >= QUAL) check(sfr_rst == 1'b1, "R3 held while pin high", sfr_rst, 1);
            rst_pin = 1'b0;
            ticks(2);
            check(sfr_rst == 1'b0, "R3 release within two edges", sfr_rst, 0);
            check(cpu_clk_en == 1'b1, "R2 cpu keeps running", cpu_clk_en, 1);
            ticks(3);
        end

        // R4 / R5 / R6 / R7 / R8 request combinations
        for (int c = 1; c <= 3; c++) begin
            idle_req = c[0];
            pd_req   = c[1];
            tick();
            idle_req = 1'b0;
            pd_req   = 1'b0;
            if (c == 1) begin
                check(ens() == 3, "R4 idle enables", ens(), 3);
                tick();
                check(ens() == 3, "R4 idle persists", ens(), 3);
                irq_pend = 1'b1;
                tick();
                irq_pend = 1'b0;
                check(cpu_clk_en == 1'b1, "R5 interrupt wakes idle", cpu_clk_en, 1);
            end else begin
                check(ens() == 0, "R6 power-down enables (priority when both)", ens(), 0);
                irq_pend = 1'b1;
                idle_req = 1'b1;
                ticks(3);
                irq_pend = 1'b0;
                idle_req = 1'b0;
                check(ens() == 0, "R7 interrupt ignored in power-down", ens(), 0);
                rst_pin = 1'b1;
                tick();
                check(ens() == 1, "R8 oscillator restarts, cpu held", ens(), 1);
                check(sfr_rst == 1'b1, "R8 reset asserted on exit", sfr_rst, 1);
                n = 0;
                while (!cpu_clk_en && n < 100) begin
                    tick();
                    n++;
                end
                check(n == START_CLKS, "R8 start-up edge count", n, START_CLKS);
                ticks(5);
                check(sfr_rst == 1'b1, "R8 reset held while pin high", sfr_rst, 1);
                rst_pin = 1'b0;
                ticks(2);
                check(sfr_rst == 1'b0, "R3 release after power-down exit", sfr_rst, 0);
            end
            ticks(2);
        end

        // R10 requests ignored during reset
        rst_pin = 1'b1;
        ticks(QUAL + 2);
        idle_req = 1'b1;
        tick();
        idle_req = 1'b0;
        check(ens() == 7, "R10 idle ignored in reset", ens(), 7);
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        check(ens() == 7, "R10 power-down ignored in reset", ens(), 7);
        rst_pin = 1'b0;
        ticks(4);

        // R9 reset pin ends idle
        idle_req = 1'b1;
        tick();
        idle_req = 1'b0;
        check(ens() == 3, "R4 idle before reset exit", ens(), 3);
        rst_pin = 1'b1;
        tick();
        check(cpu_clk_en == 1'b1, "R9 cpu resumes at once", cpu_clk_en, 1);
        check(ram_wr_inhibit == 1'b1 && sfr_rst == 1'b0, "R9 inhibit opens", ram_wr_inhibit, 1);
        win = 1;
        for (int k = 2; k <= QUAL; k++) begin
            tick();
            if (ram_wr_inhibit) win++;
            if (ram_wr_inhibit && sfr_rst) check(1'b0, "R9 overlap", 1, 0);
        end
        check(win == QUAL - 1, "R9 inhibit window length", win, QUAL - 1);
        check(ram_wr_inhibit == 1'b0 && sfr_rst == 1'b1, "R9 handover to reset", sfr_rst, 1);
        rst_pin = 1'b0;
        ticks(3);
        check(sfr_rst == 1'b0 && ram_wr_inhibit == 1'b0, "R3 release after idle exit", sfr_rst, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule